// File: doc/BRIEF.md
# Root Hub Downstream Port Control and Status Register

This block holds the control and status word for one downstream port of a USB root hub. Reading returns the port state in the low half: connection, enable, suspend, reset-in-progress, power and device speed. The high half holds sticky change flags. Writing uses the same 32-bit word, but each bit position is a command rather than a data value. Writing 1 to a bit fires its command, and writing 0 does nothing. The commands set or clear enable, suspend, reset and power, and clear the change flags.

Two detect inputs come from the port line logic: device present and low-speed device. A 12 MHz clock-enable feeds a timer that measures the port reset pulse. The block drives the port's reset and power controls. Any change flag that becomes set raises a one-cycle event toward the hub's status logic. A transaction-busy input holds back every write until the bus transaction in flight has finished.

Top module: `rh_port_reg`

## Requirements
- R1: After the synchronous reset, with the port removable, rd_data reads 0, port_pwr_o and port_rst_o are 0, and rh_change_o is 0.
- R2: rd_data[0] follows conn_det one cycle later. Every change of conn_det sets rd_data[16]. A disconnect also clears enable (bit 1), suspend (bit 2) and any reset in progress (bit 4) without setting bit 20.
- R3: Writing 1 to bit 16 or bit 20 clears that flag, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R4: Writing 1 to bit 4 while connected sets rd_data[4] and port_rst_o for exactly RST_TICKS tick-enabled cycles. Reset then ends: bit 4 clears, bit 20 sets and bit 1 (enable) sets.
- R5: A write of 1 to bit 4 (set reset), bit 1 (set enable) or bit 2 (set suspend) while disconnected changes none of those states and sets rd_data[16] instead.
- R6: Writing 1 to bit 0 clears enable and leaves rd_data[0] unchanged. Writing 1 to bit 1 sets enable, writing 1 to bit 2 sets suspend, and writing 1 to bit 3 clears suspend.
- R7: Writing 1 to bit 8 sets power (rd_data[8], port_pwr_o). Writing 1 to bit 9 clears power and enable. On read, bit 9 shows lowspd_det only while connected.
- R8: A write accepted while txn_busy is 1 has no effect until the first cycle with txn_busy at 0. It then takes effect at that clock edge.
- R9: rh_change_o is a one-cycle pulse in the cycle in which rd_data[16] or rd_data[20] goes from 0 to 1.
- R10: With NONREMOVABLE set, rd_data[0] always reads 1, rd_data[16] is 1 straight after reset, and conn_det changes never set rd_data[16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_12m | input | 1 | 12 MHz clock-enable for the reset timer |
| conn_det | input | 1 | Device present on the port |
| lowspd_det | input | 1 | Attached device is low speed |
| txn_busy | input | 1 | Bus transaction in progress; postpones writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Command bits of the write |
| rd_data | output | 32 | Status (low half) and change flags (high half) |
| port_rst_o | output | 1 | Port reset signalling active |
| port_pwr_o | output | 1 | Port power switch |
| rh_change_o | output | 1 | Pulse when a change flag becomes set |

## Verification
The main path is driven by a walked sequence of connect edges and command writes. The sequence includes all-zero writes, each of which must leave the whole word unchanged. It also includes set commands issued with no device attached, which must be turned into a connect-change flag rather than a state change. Directed cases then count the reset pulse length in ticks and separate a normal reset ending from a disconnect that aborts reset. They also check that a clear and a set landing on the same edge leave the flag set. Finally, they confirm that a write made during a busy transaction stays invisible until the busy input drops. A second instance, built as non-removable, shows the connect bit pinned high and the change flag ignoring the detect input.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  localparam int DW = 32;
  // read-side bit positions
  localparam int B_CONN    = 0;
  localparam int B_EN      = 1;
  localparam int B_SUSP    = 2;
  localparam int B_RST     = 4;
  localparam int B_PWR     = 8;
  localparam int B_LS      = 9;
  localparam int B_CSC     = 16;
  localparam int B_PRSC    = 20;
  // write-side command positions
  localparam int W_CLR_EN   = 0;
  localparam int W_SET_EN   = 1;
  localparam int W_SET_SUSP = 2;
  localparam int W_CLR_SUSP = 3;
  localparam int W_SET_RST  = 4;
  localparam int W_SET_PWR  = 8;
  localparam int W_CLR_PWR  = 9;
endpackage

// File: rtl/rh_reset_timer.sv
module rh_reset_timer #(
  parameter int RST_TICKS = 120000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

  logic [CW-1:0] cnt;

  assign done = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else if (tick)           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rh_write_hold.sv
module rh_write_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  output logic          cmd_vld,
  output logic [DW-1:0] cmd
);
  logic          pend_v;
  logic [DW-1:0] pend;

  assign cmd_vld = !busy && (pend_v || wr_en);
  assign cmd     = pend | (wr_en ? wr_data : '0);

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      pend_v <= 1'b0;
      pend   <= '0;
    end else if (wr_en) begin
      pend_v <= 1'b1;
      pend   <= pend | wr_data;
    end
  end
endmodule

// File: rtl/rh_port_reg.sv
module rh_port_reg
  import rh_port_pkg::*;
#(
  parameter int RST_TICKS    = 120000,
  parameter bit NONREMOVABLE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_12m,
  input  logic          conn_det,
  input  logic          lowspd_det,
  input  logic          txn_busy,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          port_rst_o,
  output logic          port_pwr_o,
  output logic          rh_change_o
);
  logic          cmd_vld;
  logic [DW-1:0] cmd;
  logic          rst_done;

  logic conn_q, en_q, susp_q, prst_q, pwr_q, ls_q, csc_q, prsc_q;
  logic conn_d, en_d, susp_d, prst_d, pwr_d, csc_d, prsc_d;
  logic conn_in;

  rh_write_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .busy(txn_busy), .cmd_vld(cmd_vld), .cmd(cmd)
  );

  rh_reset_timer #(.RST_TICKS(RST_TICKS)) u_timer (
    .clk(clk), .rst(rst), .run(prst_q), .tick(tick_12m), .done(rst_done)
  );

  generate
    if (NONREMOVABLE) begin : g_fixed
      assign conn_in = 1'b1;
    end else begin : g_detect
      assign conn_in = conn_det;
    end
  endgenerate

  always_comb begin
    conn_d = conn_in;
    en_d   = en_q;
    susp_d = susp_q;
    prst_d = prst_q;
    pwr_d  = pwr_q;
    csc_d  = csc_q;
    prsc_d = prsc_q;
    // software commands (clears first, sets after so sets win)
    if (cmd_vld) begin
      if (cmd[B_CSC])      csc_d  = 1'b0;
      if (cmd[B_PRSC])     prsc_d = 1'b0;
      if (cmd[W_CLR_EN])   en_d   = 1'b0;
      if (cmd[W_CLR_SUSP]) susp_d = 1'b0;
      if (cmd[W_SET_PWR])  pwr_d  = 1'b1;
      if (cmd[W_CLR_PWR]) begin
        pwr_d = 1'b0;
        en_d  = 1'b0;
      end
      if (cmd[W_SET_EN])   begin if (conn_q) en_d   = 1'b1; else csc_d = 1'b1; end
      if (cmd[W_SET_SUSP]) begin if (conn_q) susp_d = 1'b1; else csc_d = 1'b1; end
      if (cmd[W_SET_RST])  begin if (conn_q) prst_d = 1'b1; else csc_d = 1'b1; end
    end
    // reset pulse completion
    if (rst_done) begin
      prst_d = 1'b0;
      prsc_d = 1'b1;
      en_d   = 1'b1;
    end
    // connect / disconnect events
    if (conn_in != conn_q) begin
      csc_d = 1'b1;
      if (!conn_in) begin
        en_d   = 1'b0;
        susp_d = 1'b0;
        prst_d = 1'b0;
        prsc_d = prsc_q && !(cmd_vld && cmd[B_PRSC]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q      <= NONREMOVABLE;
      en_q        <= 1'b0;
      susp_q      <= 1'b0;
      prst_q      <= 1'b0;
      pwr_q       <= 1'b0;
      ls_q        <= 1'b0;
      csc_q       <= NONREMOVABLE;
      prsc_q      <= 1'b0;
      rh_change_o <= 1'b0;
    end else begin
      conn_q      <= conn_d;
      en_q        <= en_d;
      susp_q      <= susp_d;
      prst_q      <= prst_d;
      pwr_q       <= pwr_d;
      ls_q        <= lowspd_det;
      csc_q       <= csc_d;
      prsc_q      <= prsc_d;
      rh_change_o <= (csc_d && !csc_q) || (prsc_d && !prsc_q);
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[B_CONN] = conn_q;
    rd_data[B_EN]   = en_q;
    rd_data[B_SUSP] = susp_q;
    rd_data[B_RST]  = prst_q;
    rd_data[B_PWR]  = pwr_q;
    rd_data[B_LS]   = ls_q && conn_q;
    rd_data[B_CSC]  = csc_q;
    rd_data[B_PRSC] = prsc_q;
  end

  assign port_rst_o = prst_q;
  assign port_pwr_o = pwr_q;
endmodule

// File: rtl/rh_port_chk.sv
module rh_port_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] rd_data,
  input logic        port_rst_o,
  input logic        rh_change_o
);
  AST_RST_NEEDS_CONN: assert property (@(posedge clk) disable iff (rst)
    port_rst_o |-> rd_data[0]); // R5

  AST_RST_END: assert property (@(posedge clk) disable iff (rst)
    $fell(port_rst_o) |-> (rd_data[20] || !rd_data[0])); // R4

  AST_CHG_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_data[16]) || $rose(rd_data[20])) |-> rh_change_o); // R9

  AST_CHG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rh_change_o |-> ($rose(rd_data[16]) || $rose(rd_data[20]))); // R9
endmodule

bind rh_port_reg rh_port_chk u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data),
  .port_rst_o(port_rst_o), .rh_change_o(rh_change_o)
);

// File: tb/tb_rh_port_reg.sv
module tb_rh_port_reg;
  localparam int TICKS = 8;

  logic clk = 0, rst = 1, tick = 1, conn = 0, ls = 0, busy = 0, we = 0;
  logic [31:0] wd = '0;
  logic [31:0] rd, rd_nr;
  logic prst, pwr, chg, prst_nr, pwr_nr, chg_nr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rh_port_reg #(.RST_TICKS(TICKS), .NONREMOVABLE(1'b0)) dut (
    .clk(clk), .rst(rst), .tick_12m(tick), .conn_det(conn), .lowspd_det(ls),
    .txn_busy(busy), .wr_en(we), .wr_data(wd), .rd_data(rd),
    .port_rst_o(prst), .port_pwr_o(pwr), .rh_change_o(chg));

  rh_port_reg #(.RST_TICKS(TICKS), .NONREMOVABLE(1'b1)) dut_nr (
    .clk(clk), .rst(rst), .tick_12m(tick), .conn_det(conn), .lowspd_det(ls),
    .txn_busy(busy), .wr_en(we), .wr_data(wd), .rd_data(rd_nr),
    .port_rst_o(prst_nr), .port_pwr_o(pwr_nr), .rh_change_o(chg_nr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one step: drive at negedge, clock, sample at next negedge
  task automatic step(input logic c, input logic w, input logic [31:0] d);
    conn = c; we = w; wd = d;
    @(negedge clk);
    we = 0; wd = '0;
  endtask

  typedef struct packed {
    logic        c;
    logic        w;
    logic [31:0] d;
    logic [31:0] exp;
    logic        ec;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b0, 32'h0,     32'h0,     1'b0}, // idle
    '{1'b0, 1'b1, 32'h10,    32'h10000, 1'b1}, // R5 reset while disconnected
    '{1'b0, 1'b1, 32'h10000, 32'h0,     1'b0}, // R3 clear csc
    '{1'b0, 1'b1, 32'h100,   32'h100,   1'b0}, // R7 set power
    '{1'b1, 1'b0, 32'h0,     32'h10101, 1'b1}, // R2 connect
    '{1'b1, 1'b1, 32'h0,     32'h10101, 1'b0}, // R3 zero write ignored
    '{1'b1, 1'b1, 32'h10000, 32'h101,   1'b0}, // R3 clear csc
    '{1'b1, 1'b1, 32'h2,     32'h103,   1'b0}, // R6 set enable
    '{1'b1, 1'b1, 32'h4,     32'h107,   1'b0}, // R6 set suspend
    '{1'b1, 1'b1, 32'h8,     32'h103,   1'b0}, // R6 clear suspend
    '{1'b1, 1'b1, 32'h1,     32'h101,   1'b0}, // R6 clear enable, conn kept
    '{1'b1, 1'b1, 32'h2,     32'h103,   1'b0}, // R6 set enable
    '{1'b1, 1'b1, 32'h200,   32'h1,     1'b0}, // R7 clear power drops enable
    '{1'b1, 1'b1, 32'h100,   32'h101,   1'b0}, // R7 power again
    '{1'b0, 1'b0, 32'h0,     32'h10100, 1'b1}  // R2 disconnect
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rd", rd, 32'h0);
    chk("R1 pwr/rst/chg", {29'd0, pwr, prst, chg}, 32'h0);
    // R10 non-removable after reset
    chk("R10 nr conn+csc", rd_nr & 32'h10001, 32'h10001);

    for (int i = 0; i < NV; i++) begin
      step(VT[i].c, VT[i].w, VT[i].d);
      chk($sformatf("table step %0d rd", i), rd, VT[i].exp);
      chk($sformatf("R9 table step %0d chg", i), {31'd0, chg}, {31'd0, VT[i].ec});
      if (i == 4) begin
        chk("R10 nr csc ignores conn", {31'd0, rd_nr[16]}, 32'd0);
        chk("R10 nr conn reads 1", {31'd0, rd_nr[0]}, 32'd1);
      end
    end

    // R3 set wins over clear in same cycle (connect edge + clear csc)
    step(1'b1, 1'b1, 32'h10000);
    chk("R3 set wins", {31'd0, rd[16]}, 32'd1);
    step(1'b1, 1'b1, 32'h10000);
    chk("R3 cleared", {31'd0, rd[16]}, 32'd0);

    // R7 low-speed visible only while connected
    ls = 1;
    step(1'b1, 1'b0, 32'h0);
    chk("R7 ls shown", {31'd0, rd[9]}, 32'd1);

    // R4 reset pulse length and ending
    step(1'b1, 1'b1, 32'h10);
    chk("R4 reset started", {31'd0, rd[4]}, 32'd1);
    n = 0;
    while (prst && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R4 pulse ticks", n, TICKS);
    chk("R4 end state", rd & 32'h100016, 32'h100002);
    chk("R9 pulse at reset end", {31'd0, chg}, 32'd1);
    step(1'b1, 1'b1, 32'h100000);
    chk("R3 prsc cleared", {31'd0, rd[20]}, 32'd0);

    // R8 postponed write
    busy = 1;
    step(1'b1, 1'b1, 32'h1);
    chk("R8 held while busy", {31'd0, rd[1]}, 32'd1);
    @(negedge clk);
    chk("R8 still held", {31'd0, rd[1]}, 32'd1);
    busy = 0;
    @(negedge clk);
    chk("R8 applied after busy", {31'd0, rd[1]}, 32'd0);

    // R2 disconnect aborts reset without reset-change
    step(1'b1, 1'b1, 32'h10);
    step(1'b1, 1'b0, 32'h0);
    step(1'b0, 1'b0, 32'h0);
    chk("R2 abort reset", rd & 32'h110216, 32'h10000);
    chk("R2 port_rst_o low", {31'd0, prst}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule